// File: doc/BRIEF.md
# Ordered Bus-Clock Operating-Point Switch Sequencer

This block moves a complete clock domain (one PLL and the sixteen integer dividers fed by it) to a new operating point in one uninterrupted sequence. A requester presents the wanted bus rate in MHz together with the PLL rate currently in effect. The block matches the rate against a four-entry operating-point table, which gives the PLL rate to program and one divide value for each derived clock. It then drives a command to a PLL-update sub-sequencer and a series of register writes to the divider registers. The order of the two steps is chosen so that no derived clock rises above its limit during the change.

When the new PLL rate is lower than the present one, the PLL goes first, and the dividers, sized for the slower PLL, follow. Otherwise the dividers are loosened first and the PLL is raised last. A bus rate that is not in the table is refused at once, and nothing is written. The response carries the status returned by the PLL-update step. Locking the PLL and choosing a rate are left to the surrounding logic.

Top module: `opp_switch_seq`

## Requirements
- R1: While reset is low, and after it until the first request, `busy`, `rsp_valid`, `pll_cmd_valid` and `div_wr_valid` are all low.
- R2: The table maps bus rate (MHz) to PLL rate (MHz) as 200→800, 400→800, 600→600 and 800→800 (entries 0 to 3). `pll_cmd_mhz` carries the PLL rate paired with the requested bus rate.
- R3: If the paired PLL rate is strictly below `cur_pll_mhz` sampled at acceptance, `pll_cmd_valid` rises in the cycle after acceptance. No divider write occurs before `pll_done`, and all divider writes follow it.
- R4: If the paired PLL rate is greater than or equal to `cur_pll_mhz`, `div_wr_valid` rises in the cycle after acceptance. All sixteen divider writes complete before `pll_cmd_valid` rises.
- R5: The sixteen divider writes use addresses 0x180 + 0x10·k for slot k = 0..15, in increasing order, with one write per cycle in which `div_wr_ready` is high.
- R6: Each write carries the 8-bit divide value of its slot for the selected entry, listed here as entry 0/1/2/3. Slots 0, 8, 10 and 13 take 4/4/3/4. Slot 1 takes 4/2/1/1. Slots 2, 3, 4, 5, 7 and 9 take 2 in every entry. Slot 6 takes 1. Slot 11 takes 8/8/6/8. Slots 12 and 14 take 24/24/18/24. Slot 15 takes 16/16/12/16.
- R7: A divider write offered while `div_wr_ready` is low is held with the same address and data. `pll_cmd_valid` and `pll_cmd_mhz` are held until `pll_done` is seen high.
- R8: A bus rate that matches no entry gives `rsp_valid` with `rsp_status` = 1 in the cycle after acceptance, with no divider write and no PLL command.
- R9: For a table hit, `rsp_status` is 0 if `pll_fail` was low when `pll_done` was sampled, and 2 if it was high. All sixteen divider writes are issued in both cases.
- R10: `busy` is high from the cycle after acceptance up to and including the response cycle, and `rsp_valid` lasts exactly one cycle. A request is accepted only while `busy` is low, and `req_valid` raised while busy has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, taken when not busy |
| req_rate_mhz | input | 12 | Requested bus rate in MHz |
| cur_pll_mhz | input | 12 | PLL rate in effect now, in MHz |
| busy | output | 1 | Sequence in progress |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_status | output | 2 | 0 done, 1 rate refused, 2 PLL step failed |
| pll_cmd_valid | output | 1 | PLL update command pending |
| pll_cmd_mhz | output | 12 | PLL rate to program |
| pll_done | input | 1 | PLL update step finished |
| pll_fail | input | 1 | PLL update step failed, valid with pll_done |
| div_wr_valid | output | 1 | Divider write offered |
| div_wr_addr | output | 12 | Divider register address |
| div_wr_data | output | 8 | Divide value |
| div_wr_ready | input | 1 | Register port takes the write this cycle |

## Verification
Each result has a fixed point of appearance, counted from the clock edge that accepts `req_valid`. The first PLL command or divider write, and for a refused rate the response, is visible one cycle after that edge. Each later write is due one cycle after a cycle in which ready was high. The PLL step ends one cycle after `pll_done` is sampled, and the response comes one cycle after the final step. The bench keeps an ordered list of the events each request must produce and compares the outputs with its head at every falling edge, so a late, early, missing or reordered event shows up as a mismatch in that cycle. Stalls on the register port and a PLL responder with a fixed latency exercise the hold behaviour, and after every request the list must be empty and `busy` low.

// File: rtl/opp_pkg.sv
`timescale 1ns/1ps
package opp_pkg;

   // response codes
   typedef enum logic [1:0] {
      ST_OK       = 2'd0,
      ST_BAD_RATE = 2'd1,
      ST_PLL_ERR  = 2'd2
   } seq_status_e;

   // sequencer phases
   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_PLL  = 2'd1,
      PH_DIV  = 2'd2,
      PH_RESP = 2'd3
   } seq_phase_e;

   // bus rate of each operating point, MHz
   function automatic int unsigned opp_bus_mhz(input int unsigned entry);
      case (entry)
         0:       return 200;
         1:       return 400;
         2:       return 600;
         default: return 800;
      endcase
   endfunction

   // PLL rate paired with each operating point, MHz
   function automatic int unsigned opp_pll_mhz(input int unsigned entry);
      if (entry == 2) return 600;
      return 800;
   endfunction

   // divide value for one divider slot at one operating point
   function automatic logic [7:0] div_default(input int unsigned slot,
                                              input int unsigned entry);
      logic [7:0] col [4];
      case (slot)
         0, 8, 10, 13:        col = '{8'd4,  8'd4,  8'd3,  8'd4};
         1:                   col = '{8'd4,  8'd2,  8'd1,  8'd1};
         2, 3, 4, 5, 7, 9:    col = '{8'd2,  8'd2,  8'd2,  8'd2};
         6:                   col = '{8'd1,  8'd1,  8'd1,  8'd1};
         11:                  col = '{8'd8,  8'd8,  8'd6,  8'd8};
         12, 14:              col = '{8'd24, 8'd24, 8'd18, 8'd24};
         15:                  col = '{8'd16, 8'd16, 8'd12, 8'd16};
         default:             col = '{8'd0,  8'd0,  8'd0,  8'd0};
      endcase
      return col[entry[1:0]];
   endfunction

endpackage

// File: rtl/opp_lookup.sv
`timescale 1ns/1ps
// Matches a requested bus rate against every table entry in parallel.
module opp_lookup #(
   parameter int NUM_OPP = 4,
   parameter int RATE_W  = 12,
   parameter int IDX_W   = 2
) (
   input  logic [RATE_W-1:0] rate_mhz,
   output logic              hit,
   output logic [IDX_W-1:0]  idx,
   output logic [RATE_W-1:0] pll_mhz
);
   logic [NUM_OPP-1:0] match;

   generate
      for (genvar e = 0; e < NUM_OPP; e++) begin : g_cmp
         assign match[e] = (rate_mhz == RATE_W'(opp_pkg::opp_bus_mhz(e)));
      end
   endgenerate

   // lowest matching entry wins; entries are distinct so at most one hits
   always_comb begin
      hit     = |match;
      idx     = '0;
      pll_mhz = '0;
      for (int e = NUM_OPP - 1; e >= 0; e--) begin
         if (match[e]) begin
            idx     = IDX_W'(e);
            pll_mhz = RATE_W'(opp_pkg::opp_pll_mhz(e));
         end
      end
   end
endmodule

// File: rtl/div_rom.sv
`timescale 1ns/1ps
// Divide-value ROM: one row per operating point, one column per slot.
module div_rom #(
   parameter int NUM_OPP = 4,
   parameter int NUM_DIV = 16,
   parameter int DATA_W  = 8,
   parameter int IDX_W   = 2,
   parameter int SLOT_W  = 4
) (
   input  logic [IDX_W-1:0]  opp_idx,
   input  logic [SLOT_W-1:0] slot,
   output logic [DATA_W-1:0] value
);
   logic [DATA_W-1:0] row [NUM_OPP][NUM_DIV];

   generate
      for (genvar e = 0; e < NUM_OPP; e++) begin : g_opp
         for (genvar s = 0; s < NUM_DIV; s++) begin : g_slot
            assign row[e][s] = DATA_W'(opp_pkg::div_default(s, e));
         end
      end
   endgenerate

   assign value = row[opp_idx][slot];
endmodule

// File: rtl/div_walker.sv
`timescale 1ns/1ps
// Steps through the divider slots, one per accepted write.
module div_walker #(
   parameter int                NUM_DIV  = 16,
   parameter int                ADDR_W   = 12,
   parameter int                SLOT_W   = 4,
   parameter logic [ADDR_W-1:0] DIV_BASE = 12'h180,
   parameter logic [ADDR_W-1:0] DIV_STEP = 12'h010
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              active,
   input  logic              ready,
   output logic [SLOT_W-1:0] slot,
   output logic [ADDR_W-1:0] addr,
   output logic              last
);
   localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(NUM_DIV - 1);

   generate
      if (NUM_DIV == 1) begin : g_single
         assign slot = '0;
         assign last = 1'b1;
      end else begin : g_count
         logic [SLOT_W-1:0] slot_q;
         always_ff @(posedge clk) begin
            if (!rst_n)                slot_q <= '0;
            else if (active && ready)  slot_q <= (slot_q == LAST_SLOT) ? '0 : slot_q + 1'b1;
         end
         assign slot = slot_q;
         assign last = (slot_q == LAST_SLOT);
      end
   endgenerate

   assign addr = DIV_BASE + ADDR_W'(slot) * DIV_STEP;
endmodule

// File: rtl/opp_switch_seq.sv
`timescale 1ns/1ps
// Switches a PLL and its integer dividers to a new operating point,
// ordering the PLL step against the divider writes by direction of change.
module opp_switch_seq #(
   parameter int                NUM_OPP  = 4,
   parameter int                NUM_DIV  = 16,
   parameter int                RATE_W   = 12,
   parameter int                ADDR_W   = 12,
   parameter int                DATA_W   = 8,
   parameter logic [ADDR_W-1:0] DIV_BASE = 12'h180,
   parameter logic [ADDR_W-1:0] DIV_STEP = 12'h010
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [RATE_W-1:0] req_rate_mhz,
   input  logic [RATE_W-1:0] cur_pll_mhz,
   output logic              busy,
   output logic              rsp_valid,
   output logic [1:0]        rsp_status,
   output logic              pll_cmd_valid,
   output logic [RATE_W-1:0] pll_cmd_mhz,
   input  logic              pll_done,
   input  logic              pll_fail,
   output logic              div_wr_valid,
   output logic [ADDR_W-1:0] div_wr_addr,
   output logic [DATA_W-1:0] div_wr_data,
   input  logic              div_wr_ready
);
   import opp_pkg::*;

   localparam int IDX_W  = (NUM_OPP > 1) ? $clog2(NUM_OPP) : 1;
   localparam int SLOT_W = (NUM_DIV > 1) ? $clog2(NUM_DIV) : 1;
   localparam longint LAST_ADDR = longint'(DIV_BASE) + longint'(NUM_DIV - 1) * longint'(DIV_STEP);

   // elaboration checks
   generate
      if (NUM_OPP < 2 || NUM_OPP > 4) begin : g_chk_opp
         $error("opp_switch_seq: NUM_OPP must lie in 2..4");
      end
      if (NUM_DIV < 1 || NUM_DIV > 16) begin : g_chk_div
         $error("opp_switch_seq: NUM_DIV must lie in 1..16");
      end
      if (DATA_W < 5 || DATA_W > 8) begin : g_chk_data
         $error("opp_switch_seq: DATA_W must lie in 5..8");
      end
      if (RATE_W < 10) begin : g_chk_rate
         $error("opp_switch_seq: RATE_W too narrow for table rates");
      end
      if (LAST_ADDR >= (64'd1 << ADDR_W)) begin : g_chk_addr
         $error("opp_switch_seq: divider addresses exceed ADDR_W");
      end
   endgenerate

   // table lookup on the live request
   logic              lk_hit;
   logic [IDX_W-1:0]  lk_idx;
   logic [RATE_W-1:0] lk_pll;

   opp_lookup #(
      .NUM_OPP (NUM_OPP),
      .RATE_W  (RATE_W),
      .IDX_W   (IDX_W)
   ) u_lookup (
      .rate_mhz (req_rate_mhz),
      .hit      (lk_hit),
      .idx      (lk_idx),
      .pll_mhz  (lk_pll)
   );

   // sequence state
   seq_phase_e        phase;
   seq_status_e       status;
   logic [IDX_W-1:0]  opp_q;
   logic [RATE_W-1:0] pll_tgt_q;
   logic              pll_first_q;

   logic              in_div;
   logic [SLOT_W-1:0] slot;
   logic              slot_last;

   assign in_div = (phase == PH_DIV);

   div_walker #(
      .NUM_DIV  (NUM_DIV),
      .ADDR_W   (ADDR_W),
      .SLOT_W   (SLOT_W),
      .DIV_BASE (DIV_BASE),
      .DIV_STEP (DIV_STEP)
   ) u_walker (
      .clk    (clk),
      .rst_n  (rst_n),
      .active (in_div),
      .ready  (div_wr_ready),
      .slot   (slot),
      .addr   (div_wr_addr),
      .last   (slot_last)
   );

   div_rom #(
      .NUM_OPP (NUM_OPP),
      .NUM_DIV (NUM_DIV),
      .DATA_W  (DATA_W),
      .IDX_W   (IDX_W),
      .SLOT_W  (SLOT_W)
   ) u_rom (
      .opp_idx (opp_q),
      .slot    (slot),
      .value   (div_wr_data)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase       <= PH_IDLE;
         status      <= ST_OK;
         opp_q       <= '0;
         pll_tgt_q   <= '0;
         pll_first_q <= 1'b0;
      end else begin
         case (phase)
            PH_IDLE: begin
               if (req_valid) begin
                  if (lk_hit) begin
                     opp_q       <= lk_idx;
                     pll_tgt_q   <= lk_pll;
                     pll_first_q <= (lk_pll < cur_pll_mhz);
                     status      <= ST_OK;
                     // a falling PLL goes first so dividers never overshoot
                     phase       <= (lk_pll < cur_pll_mhz) ? PH_PLL : PH_DIV;
                  end else begin
                     status <= ST_BAD_RATE;
                     phase  <= PH_RESP;
                  end
               end
            end
            PH_PLL: begin
               if (pll_done) begin
                  status <= pll_fail ? ST_PLL_ERR : ST_OK;
                  phase  <= pll_first_q ? PH_DIV : PH_RESP;
               end
            end
            PH_DIV: begin
               if (div_wr_ready && slot_last) begin
                  phase <= pll_first_q ? PH_RESP : PH_PLL;
               end
            end
            default: phase <= PH_IDLE;
         endcase
      end
   end

   assign busy          = (phase != PH_IDLE);
   assign rsp_valid     = (phase == PH_RESP);
   assign rsp_status    = status;
   assign pll_cmd_valid = (phase == PH_PLL);
   assign pll_cmd_mhz   = pll_tgt_q;
   assign div_wr_valid  = in_div;

endmodule

// File: rtl/opp_switch_seq_chk.sv
`timescale 1ns/1ps
// Property checker for opp_switch_seq, attached by bind below.
module opp_switch_seq_chk #(
   parameter int                NUM_DIV  = 16,
   parameter int                RATE_W   = 12,
   parameter int                ADDR_W   = 12,
   parameter int                DATA_W   = 8,
   parameter logic [ADDR_W-1:0] DIV_BASE = 12'h180,
   parameter logic [ADDR_W-1:0] DIV_STEP = 12'h010
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic [RATE_W-1:0] cur_pll_mhz,
   input logic              busy,
   input logic              rsp_valid,
   input logic [1:0]        rsp_status,
   input logic              pll_cmd_valid,
   input logic [RATE_W-1:0] pll_cmd_mhz,
   input logic              pll_done,
   input logic              div_wr_valid,
   input logic [ADDR_W-1:0] div_wr_addr,
   input logic [DATA_W-1:0] div_wr_data,
   input logic              div_wr_ready
);
   localparam int CNT_W = $clog2(NUM_DIV + 1) + 1;
   localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(DIV_BASE + ADDR_W'(NUM_DIV - 1) * DIV_STEP);

   logic [RATE_W-1:0] cap_cur;
   logic [CNT_W-1:0]  wr_cnt;
   logic              pll_seen;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cap_cur  <= '0;
         wr_cnt   <= '0;
         pll_seen <= 1'b0;
      end else if (req_valid && !busy) begin
         cap_cur  <= cur_pll_mhz;
         wr_cnt   <= '0;
         pll_seen <= 1'b0;
      end else begin
         if (div_wr_valid && div_wr_ready) wr_cnt <= wr_cnt + 1'b1;
         if (pll_cmd_valid)                pll_seen <= 1'b1;
      end
   end

   a_r3_pll_leads: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pll_cmd_valid) && (pll_cmd_mhz < cap_cur) |-> wr_cnt == '0);

   a_r4_divs_lead: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pll_cmd_valid) && (pll_cmd_mhz >= cap_cur) |-> wr_cnt == CNT_W'(NUM_DIV));

   a_r3_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(pll_cmd_valid && div_wr_valid));

   a_r5_first_addr: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(div_wr_valid) |-> div_wr_addr == DIV_BASE);

   a_r5_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
      div_wr_valid && div_wr_ready && (div_wr_addr != LAST_ADDR)
      |=> div_wr_valid && (div_wr_addr == $past(div_wr_addr) + DIV_STEP));

   a_r7_wr_hold: assert property (@(posedge clk) disable iff (!rst_n)
      div_wr_valid && !div_wr_ready
      |=> div_wr_valid && $stable(div_wr_addr) && $stable(div_wr_data));

   a_r7_cmd_hold: assert property (@(posedge clk) disable iff (!rst_n)
      pll_cmd_valid && !pll_done |=> pll_cmd_valid && $stable(pll_cmd_mhz));

   a_r8_reject_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && (rsp_status == 2'd1) |-> (wr_cnt == '0) && !pll_seen);

   a_r9_full_sequence: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && (rsp_status != 2'd1) |-> (wr_cnt == CNT_W'(NUM_DIV)) && pll_seen);

   a_r10_busy_cover: assert property (@(posedge clk) disable iff (!rst_n)
      (pll_cmd_valid || div_wr_valid || rsp_valid) |-> busy);

   a_r10_rsp_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid);

endmodule

bind opp_switch_seq opp_switch_seq_chk #(
   .NUM_DIV  (NUM_DIV),
   .RATE_W   (RATE_W),
   .ADDR_W   (ADDR_W),
   .DATA_W   (DATA_W),
   .DIV_BASE (DIV_BASE),
   .DIV_STEP (DIV_STEP)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .req_valid     (req_valid),
   .cur_pll_mhz   (cur_pll_mhz),
   .busy          (busy),
   .rsp_valid     (rsp_valid),
   .rsp_status    (rsp_status),
   .pll_cmd_valid (pll_cmd_valid),
   .pll_cmd_mhz   (pll_cmd_mhz),
   .pll_done      (pll_done),
   .div_wr_valid  (div_wr_valid),
   .div_wr_addr   (div_wr_addr),
   .div_wr_data   (div_wr_data),
   .div_wr_ready  (div_wr_ready)
);

// File: tb/sim_opp_switch_seq.sv
`timescale 1ns/1ps
module sim_opp_switch_seq;
   localparam int RATE_W  = 12;
   localparam int ADDR_W  = 12;
   localparam int DATA_W  = 8;
   localparam int NUM_DIV = 16;
   localparam int PLL_LAT = 3;

   // expected divide values per bus rate, slot 0..15
   localparam int D200 [16] = '{4, 4, 2, 2, 2, 2, 1, 2, 4, 2, 4, 8, 24, 4, 24, 16};
   localparam int D400 [16] = '{4, 2, 2, 2, 2, 2, 1, 2, 4, 2, 4, 8, 24, 4, 24, 16};
   localparam int D600 [16] = '{3, 1, 2, 2, 2, 2, 1, 2, 3, 2, 3, 6, 18, 3, 18, 12};
   localparam int D800 [16] = '{4, 1, 2, 2, 2, 2, 1, 2, 4, 2, 4, 8, 24, 4, 24, 16};

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              req_valid = 1'b0;
   logic [RATE_W-1:0] req_rate_mhz = '0;
   logic [RATE_W-1:0] cur_pll_mhz = '0;
   logic              busy;
   logic              rsp_valid;
   logic [1:0]        rsp_status;
   logic              pll_cmd_valid;
   logic [RATE_W-1:0] pll_cmd_mhz;
   logic              pll_done = 1'b0;
   logic              pll_fail = 1'b0;
   logic              div_wr_valid;
   logic [ADDR_W-1:0] div_wr_addr;
   logic [DATA_W-1:0] div_wr_data;
   logic              div_wr_ready = 1'b1;

   always #2.5 clk = ~clk;

   opp_switch_seq u0 (
      .clk           (clk),
      .rst_n         (rst_n),
      .req_valid     (req_valid),
      .req_rate_mhz  (req_rate_mhz),
      .cur_pll_mhz   (cur_pll_mhz),
      .busy          (busy),
      .rsp_valid     (rsp_valid),
      .rsp_status    (rsp_status),
      .pll_cmd_valid (pll_cmd_valid),
      .pll_cmd_mhz   (pll_cmd_mhz),
      .pll_done      (pll_done),
      .pll_fail      (pll_fail),
      .div_wr_valid  (div_wr_valid),
      .div_wr_addr   (div_wr_addr),
      .div_wr_data   (div_wr_data),
      .div_wr_ready  (div_wr_ready)
   );

   int n_vec = 0;
   int n_bad = 0;
   int cyc   = 0;
   int wd    = 0;
   // expected events: kind 0 divider write (a=addr, b=data),
   // kind 1 PLL command (a=rate, b=fail to return), kind 2 response (a=status)
   int q_kind [$];
   int q_a    [$];
   int q_b    [$];
   bit stall_mode = 1'b0;
   int pll_wait   = 0;
   bit rsp_seen   = 1'b0;
   bit prev_rsp   = 1'b0;

   function automatic int exp_pll(input int rate);
      if (rate == 200 || rate == 400 || rate == 800) return 800;
      if (rate == 600) return 600;
      return -1;
   endfunction

   function automatic int exp_div(input int rate, input int s);
      case (rate)
         200:     return D200[s];
         400:     return D400[s];
         600:     return D600[s];
         default: return D800[s];
      endcase
   endfunction

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_vec++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic push(input int k, input int a, input int b);
      q_kind.push_back(k);
      q_a.push_back(a);
      q_b.push_back(b);
   endtask

   task automatic pop();
      void'(q_kind.pop_front());
      void'(q_a.pop_front());
      void'(q_b.pop_front());
   endtask

   // per-cycle comparison against the head of the expected event list
   always @(negedge clk) begin
      if (rst_n) begin
         bit rdy;
         cyc++;
         rdy = stall_mode ? ((cyc % 3) != 0) : 1'b1;
         div_wr_ready = rdy;
         chk(busy || !(pll_cmd_valid || div_wr_valid || rsp_valid),
             "R10 outputs active only while busy", int'(busy), 1);

         if (div_wr_valid) begin
            if (q_kind.size() == 0) begin
               chk(1'b0, "R10 unexpected divider write", int'(div_wr_addr), -1);
            end else begin
               chk(q_kind[0] == 0, "R3/R4 divider write out of order", 0, q_kind[0]);
               if (q_kind[0] == 0) begin
                  chk(int'(div_wr_addr) == q_a[0], "R5/R7 divider address", int'(div_wr_addr), q_a[0]);
                  chk(int'(div_wr_data) == q_b[0], "R6 divide value", int'(div_wr_data), q_b[0]);
                  if (rdy) pop();
               end
            end
         end

         if (pll_cmd_valid) begin
            if (q_kind.size() == 0) begin
               chk(1'b0, "R10 unexpected PLL command", int'(pll_cmd_mhz), -1);
               pll_done = 1'b0;
            end else begin
               chk(q_kind[0] == 1, "R3/R4 PLL command out of order", 1, q_kind[0]);
               chk(int'(pll_cmd_mhz) == q_a[0] || q_kind[0] != 1, "R2 PLL rate",
                   int'(pll_cmd_mhz), q_a[0]);
               if (q_kind[0] == 1 && pll_wait >= PLL_LAT) begin
                  pll_done = 1'b1;
                  pll_fail = q_b[0][0];
                  pll_wait = 0;
                  pop();
               end else begin
                  pll_done = 1'b0;
                  pll_wait++;
               end
            end
         end else begin
            pll_done = 1'b0;
            pll_fail = 1'b0;
         end

         if (rsp_valid) begin
            chk(!prev_rsp, "R10 response longer than one cycle", 1, 0);
            if (q_kind.size() == 0) begin
               chk(1'b0, "R10 unexpected response", int'(rsp_status), -1);
            end else begin
               chk(q_kind[0] == 2, "R3/R4 response before sequence end", 2, q_kind[0]);
               if (q_kind[0] == 2) begin
                  chk(int'(rsp_status) == q_a[0], "R8/R9 response status", int'(rsp_status), q_a[0]);
                  pop();
               end
            end
            rsp_seen = 1'b1;
         end
         prev_rsp = rsp_valid;
      end
   end

   // watchdog
   always @(posedge clk) begin
      wd++;
      if (wd > 150000) begin
         n_vec++;
         n_bad++;
         $display("FAIL R10 watchdog expired actual=%0d expected<%0d", wd, 150000);
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   task automatic run_req(input int rate, input int cur, input bit fail,
                          input bit stall, input bit poke);
      int  pll_new;
      bit  first;
      int  t;
      pll_new    = exp_pll(rate);
      first      = (pll_new >= 0) && (pll_new < cur);
      stall_mode = stall;
      if (pll_new < 0) begin
         push(2, 1, 0);
      end else begin
         if (first) push(1, pll_new, int'(fail));
         for (int s = 0; s < NUM_DIV; s++) push(0, 'h180 + 'h10 * s, exp_div(rate, s));
         if (!first) push(1, pll_new, int'(fail));
         push(2, fail ? 2 : 0, 0);
      end
      rsp_seen     = 1'b0;
      req_valid    = 1'b1;
      req_rate_mhz = RATE_W'(rate);
      cur_pll_mhz  = RATE_W'(cur);
      @(negedge clk);
      req_valid = 1'b0;
      if (pll_new < 0) begin
         chk(rsp_valid, "R8 refusal due one cycle after request", int'(rsp_valid), 1);
      end else begin
         chk(busy, "R10 busy one cycle after request", int'(busy), 1);
         if (first) chk(pll_cmd_valid, "R3 PLL command first", int'(pll_cmd_valid), 1);
         else       chk(div_wr_valid, "R4 divider write first", int'(div_wr_valid), 1);
      end
      if (poke) begin
         repeat (3) @(negedge clk);
         req_valid    = 1'b1;
         req_rate_mhz = RATE_W'(200);
         @(negedge clk);
         req_valid = 1'b0;
      end
      t = 0;
      while (!rsp_seen && t < 400) begin
         @(negedge clk);
         t++;
      end
      chk(rsp_seen, "R9 response delivered", int'(rsp_seen), 1);
      repeat (2) @(negedge clk);
      chk(!busy, "R10 idle after response", int'(busy), 0);
      chk(q_kind.size() == 0, "R9 every expected event seen", q_kind.size(), 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk(!busy, "R1 busy low in reset", int'(busy), 0);
      chk(!(rsp_valid || pll_cmd_valid || div_wr_valid), "R1 strobes low in reset",
          int'(rsp_valid) + int'(pll_cmd_valid) + int'(div_wr_valid), 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk(!busy && !div_wr_valid && !pll_cmd_valid && !rsp_valid, "R1 quiet after reset",
          int'(busy), 0);

      run_req(200, 800, 1'b0, 1'b0, 1'b0);   // equal PLL rate: dividers first
      run_req(600, 800, 1'b0, 1'b1, 1'b0);   // falling PLL, stalled port
      run_req(400, 600, 1'b1, 1'b0, 1'b0);   // rising PLL, PLL step fails
      run_req(600, 800, 1'b1, 1'b1, 1'b1);   // falling PLL fails, request while busy
      run_req(500, 800, 1'b0, 1'b0, 1'b0);   // rate not in table
      run_req(800, 600, 1'b0, 1'b1, 1'b1);   // rising PLL, stalls, request while busy
      run_req(0,   800, 1'b0, 1'b0, 1'b0);   // rate not in table
      run_req(200, 400, 1'b0, 1'b0, 1'b0);   // rising PLL, free port

      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule